// File: doc/BRIEF.md
# External Interrupt Trigger and Pending Controller

This block watches 24 external interrupt lines and turns them into six parent interrupt requests for a main interrupt controller. Each line has its own trigger mode. It can fire on a low level, a high level, a falling edge, a rising edge or either edge. Every line first passes through a two-stage synchronizer. A line whose trigger condition holds latches a bit in a pending register, and software clears that bit by writing 1 to it. A mask register decides which pending bits reach the parent outputs.

Lines 0 to 3 each drive a parent output of their own. Lines 4 to 7 share a fifth parent output, and lines 8 to 23 share a sixth. Software reaches the trigger-mode, mask and pending registers over a plain single-cycle register bus. A write takes effect on the clock edge on which the bus is selected. A read returns data combinationally in the same cycle.

Top module: `eic_top`

## Requirements
- R1: An input change reaches the pending register on the third rising clock edge after it is applied: two synchronizer stages, then detection. After only two edges the pending bit still holds its old value.
- R2: Mode code 0 (low level) and mode code 1 (high level) set the pending bit on every cycle the active level is present. A write-1 clear therefore does not stick while that level persists.
- R3: Mode code 2 sets the pending bit on a falling edge, code 4 on a rising edge and code 6 on either edge. The edge is found by comparing the synchronized value with the value from one cycle earlier. A steady level does not set the bit.
- R4: Mode codes 3, 5, 7 and 8 to 15 never set a pending bit.
- R5: The pending register is at offset 0xA8, with bit i belonging to line i. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a trigger and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: The mask register is at offset 0xA4. Bit i at 1 masks line i and bit i at 0 unmasks it. The register reads back what was written.
- R7: The 4-bit trigger-mode field of line i is in the register at offset 0x88 + 4*(i/8), at bit 4*(i%8). These registers read back what was written.
- R8: Parent outputs irqOut[0] to irqOut[3] each equal the pending bit of the line with the same number, ANDed with that line's inverted mask bit.
- R9: irqOut[4] is high when any of lines 4 to 7 is both pending and unmasked. irqOut[5] is high when any of lines 8 to 23 is both pending and unmasked.
- R10: During and right after reset, pending reads 0, mask reads 0xFFFFFF, every trigger-mode register reads 0 and all parent outputs are low.
- R11: Reads from any other offset return 0, and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extIn | input | 24 | External interrupt lines, asynchronous |
| busSel | input | 1 | Register bus select |
| busWr | input | 1 | Write when 1, read when 0 |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as busSel |
| irqOut | output | 6 | Parent requests: bits 0-3 direct, bit 4 for lines 4-7, bit 5 for lines 8-23 |

## Verification
A wrong trigger-mode field or a broken detector shows up within three clock edges of an input change. It appears as a pending bit that is missing or extra, and reads back at offset 0xA8. A corrupted mask bit shows up in the same cycle as a parent output that disagrees with the pending and mask readback. A clear that is lost, or that clears too much, is visible on the first read after the write. The sweep covers every line under all 16 mode codes and both starting levels, so any single-line slip in field position or parent grouping is caught.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int NUM_LINES       = 24;
  localparam int FIELD_W         = 4;
  localparam int FIELDS_PER_WORD = 8;
  localparam int DATA_W          = 32;
  localparam int ADDR_W          = 8;
  localparam int CFG_WORDS       = NUM_LINES / FIELDS_PER_WORD;
  localparam int CFG_IDX_W       = $clog2(CFG_WORDS);
  localparam int DIRECT_LINES    = 4;
  localparam int GROUP_A_LO      = DIRECT_LINES;
  localparam int GROUP_B_LO      = 8;
  localparam int NUM_PARENTS     = DIRECT_LINES + 2;

  localparam logic [ADDR_W-1:0] CFG_BASE  = 8'h88;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 8'hA4;
  localparam logic [ADDR_W-1:0] PEND_ADDR = 8'hA8;

  typedef enum logic [FIELD_W-1:0] {
    TRIG_LOW  = 4'd0,
    TRIG_HIGH = 4'd1,
    TRIG_FALL = 4'd2,
    TRIG_RISE = 4'd4,
    TRIG_BOTH = 4'd6
  } trigMode_e;

  typedef enum logic [1:0] {RD_NONE, RD_CFG, RD_MASK, RD_PEND} rdSel_e;

  typedef struct packed {
    logic [CFG_WORDS-1:0] cfgWr;
    logic                 maskWr;
    logic                 pendClr;
    rdSel_e               rdSel;
    logic [CFG_IDX_W-1:0] rdIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/eic_ctrl.sv
module eic_ctrl
  import eic_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  logic doWrite;
  assign doWrite = busSel && busWr;

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    for (int w = 0; w < CFG_WORDS; w++) begin
      if (busAddr == CFG_BASE + ADDR_W'(4 * w)) begin
        strobe.cfgWr[w] = doWrite;
        strobe.rdIdx    = CFG_IDX_W'(w);
        if (busSel) strobe.rdSel = RD_CFG;
      end
    end
    if (busAddr == MASK_ADDR) begin
      strobe.maskWr = doWrite;
      if (busSel) strobe.rdSel = RD_MASK;
    end
    if (busAddr == PEND_ADDR) begin
      strobe.pendClr = doWrite;
      if (busSel) strobe.rdSel = RD_PEND;
    end
  end
endmodule

// File: rtl/eic_datapath.sv
module eic_datapath
  import eic_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_LINES-1:0]   extIn,
  input  ctrlStrobe_t            strobe,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  output logic [NUM_PARENTS-1:0] irqOut
);
  logic [NUM_LINES-1:0] syncA, syncB, syncPrev;
  logic [NUM_LINES-1:0] trigHit, clrVec, pendReg, maskReg, activeVec;
  logic [DATA_W-1:0] cfgReg [CFG_WORDS];
  logic [CFG_WORDS*DATA_W-1:0] cfgFlat;

  function automatic logic modeHit(input logic [FIELD_W-1:0] mode,
                                   input logic prevV, input logic curV);
    case (mode)
      TRIG_LOW:  return !curV;
      TRIG_HIGH: return curV;
      TRIG_FALL: return prevV && !curV;
      TRIG_RISE: return !prevV && curV;
      TRIG_BOTH: return prevV != curV;
      default:   return 1'b0;
    endcase
  endfunction

  // two-stage synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= extIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  for (genvar w = 0; w < CFG_WORDS; w++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               cfgReg[w] <= '0;
      else if (strobe.cfgWr[w]) cfgReg[w] <= busWdata;
    end
    assign cfgFlat[w*DATA_W +: DATA_W] = cfgReg[w];
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_det
    assign trigHit[i] = modeHit(cfgFlat[i*FIELD_W +: FIELD_W], syncPrev[i], syncB[i]);
  end

  assign clrVec = strobe.pendClr ? busWdata[NUM_LINES-1:0] : '0;

  // a trigger in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendReg <= '0;
    else       pendReg <= (pendReg & ~clrVec) | trigHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskReg <= '1;
    else if (strobe.maskWr) maskReg <= busWdata[NUM_LINES-1:0];
  end

  assign activeVec = pendReg & ~maskReg;

  for (genvar p = 0; p < DIRECT_LINES; p++) begin : g_direct
    assign irqOut[p] = activeVec[p];
  end
  assign irqOut[DIRECT_LINES]     = |activeVec[GROUP_B_LO-1:GROUP_A_LO];
  assign irqOut[DIRECT_LINES + 1] = |activeVec[NUM_LINES-1:GROUP_B_LO];

  always_comb begin
    busRdata = '0;
    case (strobe.rdSel)
      RD_CFG: begin
        for (int w = 0; w < CFG_WORDS; w++)
          if (strobe.rdIdx == CFG_IDX_W'(w)) busRdata = cfgReg[w];
      end
      RD_MASK: busRdata = {{(DATA_W-NUM_LINES){1'b0}}, maskReg};
      RD_PEND: busRdata = {{(DATA_W-NUM_LINES){1'b0}}, pendReg};
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/eic_top.sv
module eic_top
  import eic_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_LINES-1:0]   extIn,
  input  logic                   busSel,
  input  logic                   busWr,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  output logic [NUM_PARENTS-1:0] irqOut
);
  ctrlStrobe_t strobe;

  eic_ctrl u_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  eic_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .extIn    (extIn),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/eic_checker.sv
module eic_checker
  import eic_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          busSel,
  input logic                          busWr,
  input logic [ADDR_W-1:0]             busAddr,
  input logic [DATA_W-1:0]             busWdata,
  input logic [NUM_PARENTS-1:0]        irqOut,
  input logic [NUM_LINES-1:0]          pend,
  input logic [NUM_LINES-1:0]          mask,
  input logic [CFG_WORDS*DATA_W-1:0]   cfgFlat
);
  logic [NUM_LINES-1:0] clrBits, badMode;
  logic maskWrite, cfgWrite;

  always_comb begin
    clrBits   = (busSel && busWr && busAddr == PEND_ADDR) ? busWdata[NUM_LINES-1:0] : '0;
    maskWrite = busSel && busWr && busAddr == MASK_ADDR;
    cfgWrite  = 1'b0;
    for (int w = 0; w < CFG_WORDS; w++)
      if (busSel && busWr && busAddr == CFG_BASE + ADDR_W'(4 * w)) cfgWrite = 1'b1;
    for (int i = 0; i < NUM_LINES; i++) begin
      case (cfgFlat[i*FIELD_W +: FIELD_W])
        4'd0, 4'd1, 4'd2, 4'd4, 4'd6: badMode[i] = 1'b0;
        default:                      badMode[i] = 1'b1;
      endcase
    end
  end

  // R5: a pending bit only falls where a write-1 clear was issued
  assert_clear_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(pend) & ~pend & ~$past(clrBits)) == '0));

  // R4: unused mode codes never raise a pending bit
  assert_bad_mode_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pend & ~$past(pend) & $past(badMode)) == '0));

  // R6: mask only changes on a mask write
  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !maskWrite |=> $stable(mask));

  // R7: trigger fields only change on a configuration write
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrite |=> $stable(cfgFlat));

  // R8: a masked direct line never drives its parent
  assert_direct_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut[DIRECT_LINES-1:0] & mask[DIRECT_LINES-1:0]) == '0);
endmodule

bind eic_top eic_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .irqOut   (irqOut),
  .pend     (u_dp.pendReg),
  .mask     (u_dp.maskReg),
  .cfgFlat  (u_dp.cfgFlat)
);

// File: tb/eic_top_tb.sv
module eic_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] extIn = 24'hFFFFFF;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic [5:0]  irqOut;

  int checks = 0;
  int failures = 0;
  logic [31:0] cfgModel [3];
  logic [23:0] maskModel;

  always #2 clk = ~clk;

  eic_top u_dut (
    .clk(clk), .rstN(rstN), .extIn(extIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = 32'h0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  function automatic logic lvlHit(input int m, input logic v);
    return (m == 0 && !v) || (m == 1 && v);
  endfunction

  function automatic logic edgeHit(input int m, input logic a, input logic b);
    return (m == 2 && a && !b) || (m == 4 && !a && b) || (m == 6 && a != b);
  endfunction

  function automatic logic [5:0] irqFor(input int i, input logic bitV);
    logic [5:0] v = 6'b0;
    if (i < 4)      v[i] = bitV;
    else if (i < 8) v[4] = bitV;
    else            v[5] = bitV;
    return v;
  endfunction

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    for (int w = 0; w < 3; w++) cfgModel[w] = 32'h0;
    maskModel = 24'hFFFFFF;

    // R10: state while reset is held
    repeat (3) @(negedge clk);
    busRead(8'hA8, rd); check("R10 pending", rd, 32'h0);
    busRead(8'hA4, rd); check("R10 mask", rd, 32'h00FFFFFF);
    for (int w = 0; w < 3; w++) begin
      busRead(8'h88 + 8'(4 * w), rd); check("R10 cfg", rd, 32'h0);
    end
    check("R10 irq", {26'h0, irqOut}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R10 irq after release", {26'h0, irqOut}, 32'h0);
    repeat (4) @(negedge clk);
    busWrite(8'hA8, 32'hFFFFFF);

    // R11: unmapped offsets
    busWrite(8'h00, 32'hFFFFFFFF);
    busWrite(8'hA0, 32'h12345678);
    busRead(8'h00, rd); check("R11 read unmapped 00", rd, 32'h0);
    busRead(8'hA0, rd); check("R11 read unmapped A0", rd, 32'h0);
    busRead(8'hA4, rd); check("R11 mask untouched", rd, 32'h00FFFFFF);
    busRead(8'h88, rd); check("R11 cfg untouched", rd, 32'h0);

    // R7 readback with a distinct pattern per word
    for (int w = 0; w < 3; w++) begin
      busWrite(8'h88 + 8'(4 * w), 32'hF0F0F0F0 ^ (32'h11111111 * (w + 1)));
      busRead(8'h88 + 8'(4 * w), rd);
      check("R7 cfg readback", rd, 32'hF0F0F0F0 ^ (32'h11111111 * (w + 1)));
      busWrite(8'h88 + 8'(4 * w), 32'h0);
    end
    repeat (4) @(negedge clk);
    busWrite(8'hA8, 32'hFFFFFF);

    // sweep: every line, every mode code, both starting levels
    for (int i = 0; i < 24; i++) begin
      for (int m = 0; m < 16; m++) begin
        for (int b = 0; b < 2; b++) begin
          logic b0, b1, expOld, expNew, expPersist;
          int w, f;
          b0 = logic'(b); b1 = !b0;
          w = i / 8; f = i % 8;
          cfgModel[w][f*4 +: 4] = 4'(m);
          busWrite(8'h88 + 8'(4 * w), cfgModel[w]);
          busRead(8'h88 + 8'(4 * w), rd);
          check("R7 field placement", rd, cfgModel[w]);
          maskModel = ~(24'h1 << i);
          busWrite(8'hA4, {8'h0, maskModel});
          extIn = 24'hFFFFFF;
          extIn[i] = b0;
          repeat (4) @(negedge clk);
          busWrite(8'hA8, 32'hFFFFFF);
          expOld = lvlHit(m, b0);
          busRead(8'hA8, rd);
          check("R5 R2 clear vs active level", rd, {8'h0, 24'(expOld) << i});
          // apply the opposite level
          extIn[i] = b1;
          @(posedge clk); @(posedge clk); @(negedge clk);
          busRead(8'hA8, rd);
          check("R1 no change after two edges", rd, {8'h0, 24'(expOld) << i});
          @(negedge clk);
          expNew = expOld | lvlHit(m, b1) | edgeHit(m, b0, b1);
          busRead(8'hA8, rd);
          if (m == 0 || m == 1)      check("R2 level mode", rd, {8'h0, 24'(expNew) << i});
          else if (m == 2 || m == 4 || m == 6) check("R3 edge mode", rd, {8'h0, 24'(expNew) << i});
          else                       check("R4 unused mode", rd, {8'h0, 24'(expNew) << i});
          if (i < 4) check("R8 direct parent", {26'h0, irqOut}, {26'h0, irqFor(i, expNew)});
          else       check("R9 grouped parent", {26'h0, irqOut}, {26'h0, irqFor(i, expNew)});
          busWrite(8'hA8, 32'h0);
          busRead(8'hA8, rd);
          check("R5 write zero ignored", rd, {8'h0, 24'(expNew) << i});
          busWrite(8'hA4, 32'hFFFFFF);
          busRead(8'hA4, rd);
          check("R6 mask readback", rd, 32'h00FFFFFF);
          check("R6 masked outputs", {26'h0, irqOut}, 32'h0);
          busWrite(8'hA8, 32'h1 << i);
          expPersist = lvlHit(m, b1);
          busRead(8'hA8, rd);
          check("R5 single clear", rd, {8'h0, 24'(expPersist) << i});
          // restore the line to a quiet state
          cfgModel[w][f*4 +: 4] = 4'd0;
          busWrite(8'h88 + 8'(4 * w), cfgModel[w]);
          extIn = 24'hFFFFFF;
          repeat (4) @(negedge clk);
          busWrite(8'hA8, 32'hFFFFFF);
        end
      end
    end

    // R9 with two groups together, then masking one line
    cfgModel[0][5*4 +: 4] = 4'd1;
    cfgModel[2][4*4 +: 4] = 4'd1;
    busWrite(8'h88, cfgModel[0]);
    busWrite(8'h90, cfgModel[2]);
    busWrite(8'hA4, 32'hFFFFFF & ~(32'h1 << 5) & ~(32'h1 << 20));
    repeat (4) @(negedge clk);
    check("R9 both groups", {26'h0, irqOut}, 32'b110000);
    busWrite(8'hA4, 32'hFFFFFF & ~(32'h1 << 20));
    check("R9 line 5 masked", {26'h0, irqOut}, 32'b100000);
    busRead(8'hA8, rd);
    check("R9 pending both", rd, (32'h1 << 5) | (32'h1 << 20));

    finishRun();
  end
endmodule